// File: doc/BRIEF.md
# Two-Digit Decimal Seconds Counter with Run/Pause Control

This block counts 00 to 59 in two BCD digits and wraps to 00 without stopping. The count steps once for each cycle in which an external enable tick is high and an internal run flag is set. Two button inputs control the run flag. The buttons are already debounced but are asynchronous to the system clock.

Each button goes through a two-stage synchronizer and a rising-edge detector. A press therefore causes exactly one action, however long the button is held.

- The start/pause button toggles the run flag.
- The clear button returns both digits to 00 and parks the counter, stopped, until start/pause is pressed again.

All state changes happen on the system clock edge, including the clear. Outputs are the two digits, the run flag and a one-cycle wrap pulse.

Top module: `bcd60_ctr`

## Requirements
- R1: The units digit (`units_o`, BCD) takes only the values 0 to 9, and a step from 9 gives 0.
- R2: The tens digit (`tens_o`, BCD) increments by one on exactly those steps where the units digit goes from 9 to 0.
- R3: The tens digit never exceeds 5, and a step from 59 gives 00.
- R4: Each start/pause press flips `running_o`. While `running_o` is 0 the digits hold their value, and a later press resumes from that value.
- R5: A clear press sets both digits to 0 and `running_o` to 0. They stay there, whatever `tick_en` does, until a start/pause press.
- R6: A step from 59 to 00 leaves `running_o` at 1, and counting continues.
- R7: If clear and start/pause presses are detected in the same cycle, clear wins: the result is 00 with `running_o` at 0.
- R8: The digits change only on a clock edge where `running_o` is 1 and `tick_en` is 1, or where a clear takes effect.
- R9: A button input first sampled high at clock edge k takes effect at edge k+2, visible after that edge. Holding the button high for any number of cycles gives exactly one action.
- R10: `wrap_o` is 1 for exactly the one cycle that follows the step from 59 to 00, and is 0 otherwise.
- R11: While `rst_n` is low at a clock edge, the digits, `running_o` and `wrap_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable tick; one step per high cycle while running |
| btn_go_i | input | 1 | Start/pause button level, asynchronous, debounced |
| btn_clr_i | input | 1 | Clear button level, asynchronous, debounced |
| units_o | output | 4 | Units digit, BCD 0 to 9 |
| tens_o | output | 4 | Tens digit, BCD 0 to 5 |
| running_o | output | 1 | Run flag; 1 while counting is enabled |
| wrap_o | output | 1 | One-cycle pulse after the step from 59 to 00 |

## Verification
A corrupted digit register shows up at once on `units_o` or `tens_o`, either as a non-BCD value or as a jump that breaks the sequence by the next enabled step. A wrong run flag shows up within one tick as a count that advances while it should hold, or holds while it should advance. A fault in the synchronizer or the edge detector moves the run flag one edge early or late, or toggles it again while a button is held. The bench compares every cycle against its own model, so any of these is reported in the cycle it occurs.

// File: rtl/bcd60_pkg.sv
// Package: shared widths and moduli for the two-digit decimal counter.
// Assumes BCD digits of four bits each.
package bcd60_pkg;
    localparam int DIGIT_W   = 4;
    localparam int UNITS_MOD = 10;
    localparam int TENS_MOD  = 6;
    localparam int SYNC_LEN  = 2;
    localparam int NUM_BTN   = 2;
    localparam int BTN_GO    = 0;
    localparam int BTN_CLR   = 1;
endpackage

// File: rtl/btn_pulse.sv
// Module: btn_pulse
// Turns one asynchronous, debounced button level into a single-cycle pulse
// on its rising edge. Uses a SYNC_LEN-stage synchronizer and one history flop.
// Assumes the input is already free of bounce.
module btn_pulse #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic pulse_o
);
    localparam int CHAIN_W = SYNC_LEN + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the button level through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], btn_i};
        end
    end

    // Rising edge: last synchronized stage high, history stage low.
    assign pulse_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/bcd_digit.sv
// Module: bcd_digit
// One decimal digit that counts modulo MODULUS. A step at MODULUS-1 returns
// the digit to 0 and raises carry_o in the same cycle. clr_i has priority
// over step_i.
module bcd_digit #(
    parameter int W       = 4,
    parameter int MODULUS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    output logic [W-1:0] val_o,
    output logic         at_max_o,
    output logic         carry_o
);
    localparam logic [W-1:0] MAX_V = W'(MODULUS - 1);

    logic [W-1:0] val_q;

    // Hold, clear, or advance the digit with wrap at MAX_V.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else if (step_i) begin
            val_q <= (val_q == MAX_V) ? '0 : val_q + 1'b1;
        end
    end

    assign val_o    = val_q;
    assign at_max_o = (val_q == MAX_V);
    assign carry_o  = step_i & at_max_o;
endmodule

// File: rtl/run_ctl.sv
// Module: run_ctl
// Keeps the run flag. A clear pulse forces it to 0 and takes priority over a
// go pulse, which flips it. Both inputs are single-cycle pulses.
module run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic go_i,
    output logic run_o
);
    logic run_q;

    // Update the run flag: clear wins, otherwise a go pulse toggles it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (clr_i) begin
            run_q <= 1'b0;
        end else if (go_i) begin
            run_q <= ~run_q;
        end
    end

    assign run_o = run_q;
endmodule

// File: rtl/bcd60_ctr.sv
// Module: bcd60_ctr
// Two-digit BCD counter 00..59 with wrap, a run/pause toggle button and a
// clear button that parks the count at 00, stopped. Both buttons are
// asynchronous but debounced. All control is synchronous to clk.
module bcd60_ctr
    import bcd60_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               btn_go_i,
    input  logic               btn_clr_i,
    output logic [DIGIT_W-1:0] units_o,
    output logic [DIGIT_W-1:0] tens_o,
    output logic               running_o,
    output logic               wrap_o
);
    logic [NUM_BTN-1:0] btn_lvl;
    logic [NUM_BTN-1:0] btn_pls;
    logic               go_pulse;
    logic               clr_pulse;
    logic               step;
    logic               units_carry;
    logic               tens_carry;
    logic               units_max;
    logic               tens_max;
    logic               wrap_q;

    assign btn_lvl[BTN_GO]  = btn_go_i;
    assign btn_lvl[BTN_CLR] = btn_clr_i;

    // One synchronizer and edge detector per button.
    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        btn_pulse #(.SYNC_LEN(SYNC_LEN)) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .btn_i  (btn_lvl[b]),
            .pulse_o(btn_pls[b])
        );
    end

    assign go_pulse  = btn_pls[BTN_GO];
    assign clr_pulse = btn_pls[BTN_CLR];

    run_ctl u_run (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(clr_pulse),
        .go_i (go_pulse),
        .run_o(running_o)
    );

    assign step = running_o & tick_en & ~clr_pulse;

    bcd_digit #(.W(DIGIT_W), .MODULUS(UNITS_MOD)) u_units (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_pulse),
        .step_i  (step),
        .val_o   (units_o),
        .at_max_o(units_max),
        .carry_o (units_carry)
    );

    bcd_digit #(.W(DIGIT_W), .MODULUS(TENS_MOD)) u_tens (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_pulse),
        .step_i  (units_carry),
        .val_o   (tens_o),
        .at_max_o(tens_max),
        .carry_o (tens_carry)
    );

    // Register the full-count rollover as a one-cycle wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= tens_carry;
        end
    end

    assign wrap_o = wrap_q;
endmodule

// File: rtl/bcd60_ctr_chk.sv
// Module: bcd60_ctr_chk
// Property checker for bcd60_ctr, attached with bind. Observes the ports and
// the two detected button pulses.
module bcd60_ctr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic [3:0] units_o,
    input logic [3:0] tens_o,
    input logic       running_o,
    input logic       wrap_o,
    input logic       go_pulse,
    input logic       clr_pulse
);
    AST_UNITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        units_o <= 4'd9); // R1

    AST_TENS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tens_o <= 4'd5); // R3

    AST_TOGGLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse && !clr_pulse) |=> (running_o != $past(running_o))); // R4

    AST_CLEAR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (units_o == 4'd0 && tens_o == 4'd0 && !running_o)); // R5

    AST_WRAP_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tick_en && units_o == 4'd9 && tens_o == 4'd5 && !go_pulse && !clr_pulse)
        |=> (running_o && wrap_o)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!running_o || !tick_en) && !clr_pulse) |=> $stable({tens_o, units_o})); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !go_pulse); // R9

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (units_o == 4'd0 && tens_o == 4'd0)); // R10
endmodule

bind bcd60_ctr bcd60_ctr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .units_o  (units_o),
    .tens_o   (tens_o),
    .running_o(running_o),
    .wrap_o   (wrap_o),
    .go_pulse (go_pulse),
    .clr_pulse(clr_pulse)
);

// File: tb/bcd60_ctr_tb.sv
// Bench for bcd60_ctr: a cycle model built from the requirements, random
// button and tick stimulus from a fixed seed, and directed corner cases.
module bcd60_ctr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       go = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] units_o, tens_o;
    logic       running_o, wrap_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bcd60_ctr u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .btn_go_i(go), .btn_clr_i(clr),
        .units_o(units_o), .tens_o(tens_o),
        .running_o(running_o), .wrap_o(wrap_o)
    );

    always #5 clk = ~clk;

    // Model state
    logic [2:0] m_go_sh = '0, m_clr_sh = '0;
    int  m_u = 0, m_t = 0;
    bit  m_run = 0, m_wrap = 0;

    function automatic int next_units(int u);
        return (u == 9) ? 0 : u + 1;
    endfunction

    function automatic int next_tens(int t, int u);
        if (u != 9) return t;
        return (t == 5) ? 0 : t + 1;
    endfunction

    // Requirement model: sync over two edges, act on the third (R9).
    always @(posedge clk) begin
        bit gp, cp, st;
        if (!rst_n) begin
            m_go_sh <= '0; m_clr_sh <= '0;
            m_u <= 0; m_t <= 0; m_run <= 0; m_wrap <= 0;
        end else begin
            gp = m_go_sh[1] & ~m_go_sh[2];
            cp = m_clr_sh[1] & ~m_clr_sh[2];
            st = m_run & tick_en & ~cp;
            m_wrap <= st && m_u == 9 && m_t == 5;
            if (cp) begin
                m_u <= 0; m_t <= 0; m_run <= 0;
            end else begin
                if (st) begin
                    m_u <= next_units(m_u);
                    m_t <= next_tens(m_t, m_u);
                end
                if (gp) m_run <= ~m_run;
            end
            m_go_sh  <= {m_go_sh[1:0], go};
            m_clr_sh <= {m_clr_sh[1:0], clr};
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 units", units_o, m_u);
            check("R2 R3 tens", tens_o, m_t);
            check("R4 run flag", running_o, m_run);
            check("R10 wrap pulse", wrap_o, m_wrap);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed;
        int wraps;
        seed = 32'h5eed;
        void'($urandom(seed));
        cycles(3);
        check("R11 reset units", units_o, 0);
        check("R11 reset tens", tens_o, 0);
        check("R11 reset run", running_o, 0);
        check("R11 reset wrap", wrap_o, 0);
        rst_n = 1'b1;

        // R9: latency and a held button acting once
        go = 1'b1;
        cycles(2);
        check("R9 no action before third edge", running_o, 0);
        cycles(1);
        check("R9 action at third edge", running_o, 1);
        cycles(10);
        check("R9 held button acts once", running_o, 1);
        go = 1'b0;
        cycles(2);

        // R6 R10: run through two rollovers with the tick always high
        tick_en = 1'b1;
        wraps = 0;
        for (int i = 0; i < 125; i++) begin
            cycles(1);
            if (wrap_o) begin
                wraps++;
                check("R6 run stays set after wrap", running_o, 1);
                check("R3 value after 59", {tens_o, units_o}, 0);
            end
        end
        check("R10 wrap count", wraps, 2);

        // R4: pause holds the value
        go = 1'b1; cycles(1); go = 1'b0; cycles(3);
        begin
            int held;
            held = {tens_o, units_o};
            cycles(20);
            check("R4 paused value held", {tens_o, units_o}, held);
        end

        // R5: clear parks the counter at 00, stopped, with ticks present
        clr = 1'b1; cycles(1); clr = 1'b0; cycles(3);
        cycles(30);
        check("R5 parked digits", {tens_o, units_o}, 0);
        check("R5 parked run", running_o, 0);

        // R7: both buttons in the same cycle
        go = 1'b1; cycles(1); go = 1'b0; cycles(4);
        check("R7 setup running", running_o, 1);
        go = 1'b1; clr = 1'b1; cycles(1); go = 1'b0; clr = 1'b0; cycles(3);
        check("R7 clear wins run", running_o, 0);
        check("R7 clear wins digits", {tens_o, units_o}, 0);

        // R8: random tick, presses of random length
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            tick_en = (r < 70);
            if (r < 3) go = ~go;
            else if (r == 3) clr = 1'b1;
            else if (r < 8) clr = 1'b0;
            cycles(1);
        end
        go = 1'b0; clr = 1'b0;
        cycles(4);

        // R11: reset in mid-count
        go = 1'b1; cycles(1); go = 1'b0; cycles(10);
        rst_n = 1'b0; cycles(2);
        check("R11 mid-run reset digits", {tens_o, units_o}, 0);
        check("R11 mid-run reset run", running_o, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule